// File: doc/BRIEF.md
# Instruction-Fetch Way Memoization Controller

This controller decides, for each instruction fetch, whether the instruction cache needs a tag lookup. It also decides which data ways must be powered. It keeps the way that served the previous fetch. When the next fetch stays inside the same cache line as the current one, it reuses that way and disables the tag array and every other way.

When the fetch leaves the line, the controller forms a base/displacement pair for an external recent-address buffer. The pair depends on the flow kind:
- sequential flow uses the program counter plus the fetch stride;
- a taken branch uses the program counter plus the branch offset;
- a return uses the link register.

If that buffer reports a hit with a way number, only that way is enabled and the tag array stays off. Otherwise the tag array and all ways are enabled. The way that the cache resolves is then recorded.

The controller is built around a two-state tracker: `WAY_UNKNOWN` and `WAY_KNOWN`. Its transitions are:
- LEARN (`WAY_UNKNOWN` to `WAY_KNOWN`): taken on any completed fetch.
- FORGET (any state to `WAY_UNKNOWN`): taken on flush or reset.
- IDLE_HOLD (either state to itself): taken when no fetch completes.

Top module: `wm_ifetch_way_memo`

## Requirements
- R1: After reset or a cycle with `flush` high, the tracker is in `WAY_UNKNOWN`. The next fetch then gets no same-line reuse: `buf_query` is 1 even if the next address shares the line.
- R2: In `WAY_KNOWN`, a fetch whose next address has the same bits [ADDR_W-1:5] as `pc` reuses the held way. `tag_disable`=1, `way_disable` has a 0 only at the held way, `buf_query`=0, and `buf_hit` has no effect.
- R3: `flow_kind`=2'b00 (sequential) drives `buf_base`=`pc`, `buf_disp`=8 and `next_addr`=`pc`+8.
- R4: `flow_kind`=2'b01 (taken branch) drives `buf_base`=`pc`, `buf_disp`=`br_offset` and `next_addr`=`pc`+`br_offset`.
- R5: `flow_kind`=2'b10 (return to link) drives `buf_base`=`link_addr`, `buf_disp`=0 and `next_addr`=`link_addr`.
- R6: A fetch that is not reused and has `buf_hit`=1 gives `tag_disable`=1, with `way_disable` clear only at bit `buf_way`.
- R7: A fetch that is neither reused nor a buffer hit gives `tag_disable`=0 and `way_disable`=0 (a full lookup).
- R8: After each completed fetch, the held way becomes one of three values:
  - the previous held way, on reuse;
  - `buf_way`, on a buffer hit;
  - `cache_way`, otherwise.
- R9: With `fetch_valid`=0, `tag_disable`=1, `way_disable` is all ones and `buf_query`=0, and the held way and state do not change.
- R10: `flow_kind`=2'b11 behaves exactly as sequential flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Forget the held way |
| fetch_valid | input | 1 | A fetch completes this cycle |
| flow_kind | input | 2 | 00 sequential, 01 branch, 10 return, 11 sequential |
| pc | input | ADDR_W | Current fetch address |
| br_offset | input | ADDR_W | Sign-extended branch displacement |
| link_addr | input | ADDR_W | Link-register address |
| buf_hit | input | 1 | Recent-address buffer hit |
| buf_way | input | WAY_W | Way reported by the buffer |
| cache_way | input | WAY_W | Way resolved by a full lookup |
| buf_base | output | ADDR_W | Base operand to the buffer |
| buf_disp | output | ADDR_W | Displacement operand to the buffer |
| buf_query | output | 1 | Buffer lookup is needed |
| next_addr | output | ADDR_W | Address of the next fetch |
| tag_disable | output | 1 | Tag array off |
| way_disable | output | NUM_WAYS | Per-way disable |

## Verification
The bench builds the controller with its defaults: 32-bit addresses, 32-byte lines, an 8-byte stride and two ways. With these values, three of every four sequential fetches stay in the line, so reuse, line crossing and learning all occur often in a run that follows its own predicted addresses. Random branch offsets and link targets bring both the same-line and line-crossing cases into reach for non-sequential flows. Flushes land mid-stream and show the unknown-way path.

// File: rtl/wm_pkg.sv
package wm_pkg;
    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'b00,
        FLOW_BRANCH = 2'b01,
        FLOW_RETURN = 2'b10,
        FLOW_ALT    = 2'b11
    } flow_e;

    typedef enum logic {
        WAY_UNKNOWN = 1'b0,
        WAY_KNOWN   = 1'b1
    } track_e;
endpackage

// File: rtl/wm_operand_sel.sv
module wm_operand_sel #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 8
) (
    input  logic [1:0]        flow,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] br_offset,
    input  logic [ADDR_W-1:0] link_addr,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] disp
);
    import wm_pkg::*;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    always_comb begin
        unique case (flow_e'(flow))
            FLOW_BRANCH: begin
                base = pc;
                disp = br_offset;
            end
            FLOW_RETURN: begin
                base = link_addr;
                disp = '0;
            end
            default: begin
                base = pc;
                disp = STEP;
            end
        endcase
    end
endmodule

// File: rtl/wm_way_tracker.sv
module wm_way_tracker #(
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fetch_valid,
    input  logic             reuse,
    input  logic             buf_hit,
    input  logic [WAY_W-1:0] buf_way,
    input  logic [WAY_W-1:0] cache_way,
    output logic             known,
    output logic [WAY_W-1:0] held_way
);
    import wm_pkg::*;

    track_e           state_q, state_d;
    logic [WAY_W-1:0] way_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WAY_UNKNOWN;
            held_way <= '0;
        end else begin
            state_q  <= state_d;
            held_way <= way_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAY_UNKNOWN: if (flush)            state_d = WAY_UNKNOWN;
                         else if (fetch_valid) state_d = WAY_KNOWN;
            WAY_KNOWN:   if (flush)            state_d = WAY_UNKNOWN;
            default:     state_d = WAY_UNKNOWN;
        endcase
    end

    always_comb begin
        way_d = held_way;
        if (fetch_valid) begin
            if (reuse)        way_d = held_way;
            else if (buf_hit) way_d = buf_way;
            else              way_d = cache_way;
        end
    end

    assign known = (state_q == WAY_KNOWN);

    AST_FLUSH_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !known); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !flush) |=> ($stable(held_way) && $stable(known))); // R9
endmodule

// File: rtl/wm_gate_decode.sv
module wm_gate_decode #(
    parameter int NUM_WAYS = 2,
    parameter int WAY_W    = 1
) (
    input  logic                fetch_valid,
    input  logic                reuse,
    input  logic                buf_hit,
    input  logic [WAY_W-1:0]    held_way,
    input  logic [WAY_W-1:0]    buf_way,
    output logic                tag_disable,
    output logic [NUM_WAYS-1:0] way_disable,
    output logic                buf_query
);
    logic [WAY_W-1:0]    sel_way;
    logic [NUM_WAYS-1:0] sel_onehot;

    assign sel_way = reuse ? held_way : buf_way;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign sel_onehot[w] = (sel_way == WAY_W'(w));
    end

    always_comb begin
        buf_query = fetch_valid && !reuse;
        if (!fetch_valid) begin
            tag_disable = 1'b1;
            way_disable = '1;
        end else if (reuse || buf_hit) begin
            tag_disable = 1'b1;
            way_disable = ~sel_onehot;
        end else begin
            tag_disable = 1'b0;
            way_disable = '0;
        end
    end
endmodule

// File: rtl/wm_ifetch_way_memo.sv
module wm_ifetch_way_memo #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int STRIDE     = 8,
    parameter int NUM_WAYS   = 2,
    parameter int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                fetch_valid,
    input  logic [1:0]          flow_kind,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [ADDR_W-1:0]   br_offset,
    input  logic [ADDR_W-1:0]   link_addr,
    input  logic                buf_hit,
    input  logic [WAY_W-1:0]    buf_way,
    input  logic [WAY_W-1:0]    cache_way,
    output logic [ADDR_W-1:0]   buf_base,
    output logic [ADDR_W-1:0]   buf_disp,
    output logic                buf_query,
    output logic [ADDR_W-1:0]   next_addr,
    output logic                tag_disable,
    output logic [NUM_WAYS-1:0] way_disable
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    logic             known;
    logic [WAY_W-1:0] held_way;
    logic             same_line;
    logic             reuse;

    wm_operand_sel #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_sel (
        .flow(flow_kind), .pc(pc), .br_offset(br_offset),
        .link_addr(link_addr), .base(buf_base), .disp(buf_disp)
    );

    assign next_addr = buf_base + buf_disp;
    assign same_line = (next_addr[ADDR_W-1:OFS_W] == pc[ADDR_W-1:OFS_W]);
    assign reuse     = fetch_valid && known && same_line;

    wm_way_tracker #(.WAY_W(WAY_W)) u_track (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
        .reuse(reuse), .buf_hit(buf_hit), .buf_way(buf_way),
        .cache_way(cache_way), .known(known), .held_way(held_way)
    );

    wm_gate_decode #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_gate (
        .fetch_valid(fetch_valid), .reuse(reuse), .buf_hit(buf_hit),
        .held_way(held_way), .buf_way(buf_way), .tag_disable(tag_disable),
        .way_disable(way_disable), .buf_query(buf_query)
    );

    AST_REUSE_NO_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
        reuse |-> (!buf_query && tag_disable)); // R2
    AST_GATED_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && tag_disable) |-> ($countones(~way_disable) == 1)); // R6
    AST_MISS_OPENS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !tag_disable) |-> (way_disable == '0 && buf_query)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (tag_disable && (&way_disable) && !buf_query)); // R9
    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_kind == 2'b10) |-> (next_addr == link_addr)); // R5
endmodule

// File: tb/wm_ifetch_way_memo_bench.sv
module wm_ifetch_way_memo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [1:0]  flow_kind = 2'b00;
    logic [31:0] pc = '0, br_offset = '0, link_addr = '0;
    logic        buf_hit = 1'b0;
    logic        buf_way = 1'b0, cache_way = 1'b0;
    logic [31:0] buf_base, buf_disp, next_addr;
    logic        buf_query, tag_disable;
    logic [1:0]  way_disable;

    int n_cmp = 0, n_bad = 0;
    bit exp_known = 0;
    bit exp_way = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wm_ifetch_way_memo u_wm_ifetch_way_memo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
        .flow_kind(flow_kind), .pc(pc), .br_offset(br_offset),
        .link_addr(link_addr), .buf_hit(buf_hit), .buf_way(buf_way),
        .cache_way(cache_way), .buf_base(buf_base), .buf_disp(buf_disp),
        .buf_query(buf_query), .next_addr(next_addr),
        .tag_disable(tag_disable), .way_disable(way_disable)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_next(logic [1:0] fk, logic [31:0] p,
                                           logic [31:0] o, logic [31:0] l);
        if (fk == 2'b01) return p + o;
        if (fk == 2'b10) return l;
        return p + 32'd8;
    endfunction

    function automatic logic [1:0] f_mask(bit w);
        return ~(2'b01 << w);
    endfunction

    // Drive one fetch after the falling edge, check, then advance the model at the rising edge.
    task automatic step(bit fv, bit fl, logic [1:0] fk, logic [31:0] p,
                        logic [31:0] o, logic [31:0] l, bit bh, bit bw, bit cw);
        logic [31:0] nx;
        bit same;
        string rq;
        @(negedge clk);
        fetch_valid = fv; flush = fl; flow_kind = fk; pc = p; br_offset = o;
        link_addr = l; buf_hit = bh; buf_way = bw; cache_way = cw;
        #1;
        nx = f_next(fk, p, o, l);
        same = exp_known && fv && (nx[31:5] == p[31:5]);
        rq = (fk == 2'b01) ? "R4" : (fk == 2'b10) ? "R5" : (fk == 2'b11) ? "R10" : "R3";
        chk(rq, next_addr, nx);
        chk(rq, buf_base, (fk == 2'b10) ? l : p);
        chk(rq, buf_disp, (fk == 2'b01) ? o : (fk == 2'b10) ? 32'd0 : 32'd8);
        if (!fv) begin
            chk("R9", {29'd0, tag_disable, way_disable}, {29'd0, 1'b1, 2'b11});
            chk("R9", {31'd0, buf_query}, 32'd0);
        end else if (same) begin
            chk("R2/R8", {29'd0, tag_disable, way_disable}, {29'd0, 1'b1, f_mask(exp_way)});
            chk("R2", {31'd0, buf_query}, 32'd0);
        end else begin
            chk("R1", {31'd0, buf_query}, 32'd1);
            if (bh) chk("R6", {29'd0, tag_disable, way_disable}, {29'd0, 1'b1, f_mask(bw)});
            else    chk("R7", {29'd0, tag_disable, way_disable}, 32'd0);
        end
        @(posedge clk);
        if (fv) exp_way = same ? exp_way : (bh ? bw : cw);
        exp_known = fl ? 1'b0 : (fv ? 1'b1 : exp_known);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] p;
        // Reset state: idle outputs
        #12;
        chk("R9", {29'd0, tag_disable, way_disable, buf_query}, {28'd0, 1'b1, 2'b11, 1'b0});
        @(negedge clk); rst_n = 1'b1;
        // R1: first fetch after reset, same line, still queries; miss records cache way 1
        step(1, 0, 2'b00, 32'h100, 0, 0, 0, 0, 1);
        // R8: same-line reuse of way 1 while the buffer claims way 0 (ignored, R2)
        step(1, 0, 2'b00, 32'h108, 0, 0, 1, 0, 0);
        // R6: line crossing with buffer hit way 0
        step(1, 0, 2'b00, 32'h118, 0, 0, 1, 0, 1);
        step(1, 0, 2'b00, 32'h120, 0, 0, 0, 1, 1);
        // R9: idle holds
        step(0, 0, 2'b01, 32'h200, 32'h40, 0, 1, 1, 1);
        step(1, 0, 2'b10, 32'h300, 0, 32'h304, 0, 0, 0);
        // R1: flush then same-line must query
        step(1, 1, 2'b00, 32'h400, 0, 0, 0, 0, 1);
        step(1, 0, 2'b00, 32'h408, 0, 0, 0, 0, 0);
        // R4: short backward branch in the same line, far branch
        step(1, 0, 2'b01, 32'h41C, 32'hFFFF_FFF4, 0, 0, 1, 1);
        step(1, 0, 2'b01, 32'h410, 32'h1000, 0, 0, 1, 1);
        // R10: alternate code behaves as sequential
        step(1, 0, 2'b11, 32'h1410, 0, 0, 1, 1, 0);
        // Random mix following predicted addresses
        p = 32'h2000;
        for (int i = 0; i < 3000; i++) begin
            bit fv, fl, bh, bw, cw;
            logic [1:0] fk;
            logic [31:0] o, l;
            fv = ($urandom % 8) != 0;
            fl = ($urandom % 40) == 0;
            fk = 2'($urandom % 4);
            if ($urandom % 3 != 0) fk = 2'b00;
            o = ($urandom % 2) ? 32'($signed(8'($urandom))) : 32'($urandom % 4096);
            l = p + 32'($urandom % 64) - 32'd32;
            bh = $urandom % 2; bw = $urandom % 2; cw = $urandom % 2;
            if ($urandom % 50 == 0) p = $urandom;
            step(fv, fl, fk, p, o, l, bh, bw, cw);
            if (fv) p = f_next(fk, p, o, l);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule